// File: doc/BRIEF.md
# A1 Word Aligner for a Serial Byte Deserializer

The block turns a serial bit stream, one bit per clock, into 8-bit words with a one-cycle word strobe. After reset the word boundary is wherever the internal bit counter happens to start. To lock the boundary to the line's framing, a controller requests a hunt. In the hunt the block looks at the last eight received bits on every clock for the framing byte 0xF6 (11110110, first received bit leftmost). It accepts the byte at any bit offset. On the first match it emits that byte as a complete word and restarts its bit counter from it, so every later word falls on the framed boundary.

A hunt is requested by a falling edge on the active-low input `hunt_req_n` while `hunt_block` is low. The hunt ends on any of three events: a match, a pulse on `frame_found` from the downstream frame detector, or a falling edge on `hunt_req_n` while `hunt_block` is high. Once the hunt has ended, framing patterns in the data do not move the boundary until another arming edge arrives.

The controller has three states. FREE is the reset state, with a free-running boundary. HUNT means searching. LOCK means aligned by a match. The transitions are:
- FREE to HUNT, and LOCK to HUNT, on an arming edge.
- HUNT to LOCK on a match.
- HUNT to FREE on `frame_found`, or on a falling edge with `hunt_block` high.
- HUNT to HUNT on a repeated arming edge, which restarts the search.

Top module: `a1_word_aligner`

## Requirements
- R1: While reset is active, and in the first cycle after it, `word_out` is 0, `word_stb` is 0, `word_ok` is 0 and `hunt_active` is 0.
- R2: A word carries eight consecutive received bits, with the earliest in bit 7 (MSB) and the latest in bit 0 (LSB).
- R3: Outside HUNT, `word_stb` is a single-cycle pulse once every 8 clocks.
- R4: When `hunt_req_n` is sampled low after being high and `hunt_block` is low, `hunt_active` is 1 from the next cycle. No word is strobed at that edge.
- R5: In HUNT, when the last 8 bits equal 0xF6 at any offset, that byte is strobed in the same edge. The next words follow every 8 clocks, aligned to it.
- R6: In HUNT, `word_stb` stays 0 except on the match. `word_ok` drops at the arming edge and returns to 1 with the next strobed word.
- R7: `frame_found` high in HUNT, with no falling edge in the same cycle, returns the block to FREE without moving the boundary.
- R8: A falling edge on `hunt_req_n` with `hunt_block` high ends a hunt. In FREE or LOCK it has no effect.
- R9: Outside HUNT, a 0xF6 pattern in the data leaves the word boundary unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| hunt_req_n | input | 1 | Active-low out-of-frame request; its falling edge acts |
| hunt_block | input | 1 | When high, a falling request edge stops a hunt instead of arming one |
| frame_found | input | 1 | Frame-detected pulse from the downstream detector; stops a hunt |
| word_out | output | 8 | Parallel word, earliest bit in MSB |
| word_stb | output | 1 | One-cycle strobe marking a new word |
| word_ok | output | 1 | Words are valid (not between arming and first aligned word) |
| hunt_active | output | 1 | Search for the framing byte is running |

## Verification
The framing byte is inserted after zero fill at each of the eight bit offsets. The three bytes after the match must come out as 0xF6 0xF6 0x28. A design that kept its old boundary, or that reversed bit order, would emit shifted or mirrored bytes. After lock, and after a hunt stopped by `frame_found`, the byte is sent three bits off the boundary; a design that realigned anyway would show 0xF6 instead of 0x1E then 0xC0. Falling request edges with `hunt_block` high are applied both during a hunt and outside one, to catch a design that arms on them or ignores them. A reference model compared every clock also catches stray strobes during the hunt and a `word_ok` flag that does not drop at arming.

// File: rtl/aw_pkg.sv
package aw_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } aw_state_e;
endpackage

// File: rtl/aw_front.sv
// Serial window and falling-edge detection of the hunt request.
module aw_front #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         hunt_req_n,
    output logic [W-1:0] win_next,
    output logic         fall_ev
);
    logic [W-1:0] win_q;
    logic         req_q;

    assign win_next = {win_q[W-2:0], ser_in};
    assign fall_ev  = req_q & ~hunt_req_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            req_q <= 1'b1;
        end else begin
            win_q <= win_next;
            req_q <= hunt_req_n;
        end
    end
endmodule

// File: rtl/aw_hunt_fsm.sv
// Hunt controller: FREE / HUNT / LOCK.
module aw_hunt_fsm
    import aw_pkg::*;
#(
    parameter int         W       = 8,
    parameter logic [W-1:0] PATTERN = 8'hF6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_ev,
    input  logic         hunt_block,
    input  logic         frame_found,
    input  logic [W-1:0] win_next,
    output logic         hunt_active,
    output logic         align_load,
    output logic         arm
);
    aw_state_e state, state_nx;
    logic      match;

    assign match = (win_next == PATTERN);
    assign arm   = fall_ev & ~hunt_block;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FREE, ST_LOCK: begin
                if (arm) state_nx = ST_HUNT;
            end
            ST_HUNT: begin
                if (arm)                         state_nx = ST_HUNT;
                else if (fall_ev || frame_found) state_nx = ST_FREE;
                else if (match)                  state_nx = ST_LOCK;
            end
            default: state_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        hunt_active = (state == ST_HUNT);
        align_load  = (state == ST_HUNT) && !fall_ev && !frame_found && match;
    end

    p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && !hunt_block) |=> (state == ST_HUNT));
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && hunt_block && state == ST_HUNT) |=> (state == ST_FREE));
    p_frame_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && frame_found && !fall_ev) |=> (state == ST_FREE));
    p_no_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && hunt_block && state != ST_HUNT) |=> (state != ST_HUNT));
endmodule

// File: rtl/aw_word_out.sv
// Bit counter, word register, strobe and validity flag.
module aw_word_out #(
    parameter int           W       = 8,
    parameter logic [W-1:0] PATTERN = 8'hF6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] win_next,
    input  logic         align_load,
    input  logic         arm,
    input  logic         hunt_active,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         word_ok
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = (cnt == LAST) ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            word_out <= '0;
            word_stb <= 1'b0;
            word_ok  <= 1'b0;
        end else if (align_load) begin
            cnt      <= '0;
            word_out <= win_next;
            word_stb <= 1'b1;
            word_ok  <= 1'b1;
        end else if (arm) begin
            cnt      <= cnt_inc;
            word_stb <= 1'b0;
            word_ok  <= 1'b0;
        end else if (hunt_active) begin
            cnt      <= cnt_inc;
            word_stb <= 1'b0;
        end else begin
            cnt <= cnt_inc;
            if (cnt == LAST) begin
                word_out <= win_next;
                word_stb <= 1'b1;
                word_ok  <= 1'b1;
            end else begin
                word_stb <= 1'b0;
            end
        end
    end

    p_hunt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_active && !align_load) |=> !word_stb);
    p_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> word_ok);
    p_align_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        align_load |=> (word_stb && word_out == PATTERN));
    p_single_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);
endmodule

// File: rtl/a1_word_aligner.sv
module a1_word_aligner #(
    parameter int           W       = 8,
    parameter logic [W-1:0] PATTERN = 8'hF6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         hunt_req_n,
    input  logic         hunt_block,
    input  logic         frame_found,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         word_ok,
    output logic         hunt_active
);
    logic [W-1:0] win_next;
    logic         fall_ev;
    logic         align_load;
    logic         arm;

    aw_front #(.W(W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .hunt_req_n (hunt_req_n),
        .win_next   (win_next),
        .fall_ev    (fall_ev)
    );

    aw_hunt_fsm #(.W(W), .PATTERN(PATTERN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_ev     (fall_ev),
        .hunt_block  (hunt_block),
        .frame_found (frame_found),
        .win_next    (win_next),
        .hunt_active (hunt_active),
        .align_load  (align_load),
        .arm         (arm)
    );

    aw_word_out #(.W(W), .PATTERN(PATTERN)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_next    (win_next),
        .align_load  (align_load),
        .arm         (arm),
        .hunt_active (hunt_active),
        .word_out    (word_out),
        .word_stb    (word_stb),
        .word_ok     (word_ok)
    );
endmodule

// File: tb/test_a1_word_aligner.sv
module test_a1_word_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       hunt_req_n = 1'b1;
    logic       hunt_block = 1'b0;
    logic       frame_found = 1'b0;
    logic [7:0] word_out;
    logic       word_stb, word_ok, hunt_active;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit   mq[$];
    int   mst, mcnt, e_par;
    bit   e_stb, e_ok, prev_req;
    logic [7:0] got[$];

    always #2.5 clk = ~clk;

    a1_word_aligner i_a1_word_aligner (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .hunt_req_n(hunt_req_n),
        .hunt_block(hunt_block), .frame_found(frame_found), .word_out(word_out),
        .word_stb(word_stb), .word_ok(word_ok), .hunt_active(hunt_active)
    );

    function automatic void chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    task automatic model_step();
        int  nw;
        bit  fall;
        int  old;
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < 8; i++) mq.push_back(1'b0);
            mst = 0; mcnt = 0; e_par = 0; e_stb = 0; e_ok = 0; prev_req = 1;
            return;
        end
        mq.push_back(ser_in);
        void'(mq.pop_front());
        nw = 0;
        for (int i = 0; i < 8; i++) nw = (nw << 1) | int'(mq[i]);
        fall = prev_req && !hunt_req_n;
        prev_req = hunt_req_n;
        old = mst;
        e_stb = 0;
        if (old == 1 && !fall && !frame_found && nw == 'hF6) begin
            e_par = nw; e_stb = 1; e_ok = 1; mst = 2; mcnt = 0;
        end else begin
            if (fall && !hunt_block) begin
                mst = 1; e_ok = 0;
            end else if (old == 1 && (fall || frame_found)) begin
                mst = 0;
            end else if (old != 1 && mcnt == 7) begin
                e_par = nw; e_stb = 1; e_ok = 1;
            end
            mcnt = (mcnt + 1) % 8;
        end
    endtask

    task automatic tick(input logic b);
        ser_in = b;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(word_stb == e_stb, "R3 strobe vs model", word_stb, e_stb);
        chk(word_ok == e_ok, "R6 word_ok vs model", word_ok, e_ok);
        chk(hunt_active == (mst == 1), "R4 hunt_active vs model", hunt_active, mst == 1);
        if (e_stb) chk(word_out == e_par[7:0], "R2 word vs model", word_out, e_par);
        if (word_stb) got.push_back(word_out);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tick(v[i]);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    task automatic arm_hunt();
        hunt_block = 1'b0;
        hunt_req_n = 1'b0;
        tick(1'b0);
        chk(hunt_active == 1'b1, "R4 armed", hunt_active, 1);
        chk(word_ok == 1'b0, "R6 word_ok low after arm", word_ok, 0);
        got.delete();
        zeros(9);
        hunt_req_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cnt_stb;
        zeros(3);
        chk(word_out == 8'h00, "R1 reset word", word_out, 0);
        chk(word_stb == 1'b0, "R1 reset strobe", word_stb, 0);
        chk(word_ok == 1'b0, "R1 reset word_ok", word_ok, 0);
        chk(hunt_active == 1'b0, "R1 reset hunt", hunt_active, 0);
        rst_n = 1'b1;
        tick(1'b1);
        chk(word_stb == 1'b0 && word_ok == 1'b0, "R1 first cycle", word_ok, 0);

        // R3: free run strobe rate, R9 ignores patterns
        got.delete();
        for (int i = 0; i < 64; i++) tick(1'($urandom));
        cnt_stb = got.size();
        chk(cnt_stb == 8, "R3 eight strobes in 64 clocks", cnt_stb, 8);

        // R5/R2: framing byte at each bit offset
        for (int off = 0; off < 8; off++) begin
            arm_hunt();
            zeros(off);
            send_byte(8'hF6); send_byte(8'hF6); send_byte(8'hF6);
            send_byte(8'h28); send_byte(8'h28); send_byte(8'h28);
            zeros(16);
            chk(got.size() >= 6, "R5 word count", got.size(), 6);
            if (got.size() >= 6) begin
                chk(got[0] == 8'hF6, "R5 matched word", got[0], 8'hF6);
                chk(got[2] == 8'hF6, "R5 aligned A1", got[2], 8'hF6);
                chk(got[3] == 8'h28, "R2 aligned A2 order", got[3], 8'h28);
            end
            chk(hunt_active == 1'b0, "R5 hunt ends on match", hunt_active, 0);
            chk(word_ok == 1'b1, "R6 word_ok after align", word_ok, 1);
        end

        // R9: pattern off boundary while locked
        got.delete();
        zeros(3); send_byte(8'hF6); zeros(5);
        chk(got.size() == 2, "R9 word count", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 8'h1E, "R9 no realign first", got[0], 8'h1E);
            chk(got[1] == 8'hC0, "R9 no realign second", got[1], 8'hC0);
        end

        // R7: frame_found stops hunt, boundary kept
        arm_hunt();
        frame_found = 1'b1;
        tick(1'b0);
        frame_found = 1'b0;
        chk(hunt_active == 1'b0, "R7 frame_found stops hunt", hunt_active, 0);
        got.delete();
        zeros(5); zeros(3); send_byte(8'hF6); zeros(5);
        chk(got.size() == 3, "R7 word count", got.size(), 3);
        if (got.size() == 3) begin
            chk(got[1] == 8'h1E, "R7 boundary kept", got[1], 8'h1E);
            chk(got[2] == 8'hC0, "R7 boundary kept tail", got[2], 8'hC0);
        end

        // R8: disabled falling edge stops hunt / does not arm
        arm_hunt();
        tick(1'b0);
        hunt_block = 1'b1;
        hunt_req_n = 1'b0;
        tick(1'b0);
        chk(hunt_active == 1'b0, "R8 blocked edge stops hunt", hunt_active, 0);
        zeros(3);
        hunt_req_n = 1'b1;
        tick(1'b0);
        hunt_req_n = 1'b0;
        tick(1'b0);
        chk(hunt_active == 1'b0, "R8 blocked edge no arm", hunt_active, 0);
        zeros(2);
        got.delete();
        send_byte(8'hF6); send_byte(8'hF6);
        chk(hunt_active == 1'b0, "R8 still not hunting", hunt_active, 0);
        hunt_req_n = 1'b1;
        hunt_block = 1'b0;
        zeros(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule